// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives several pulse-width outputs that all run on one common period. A power-of-two prescaler divides the clock into count ticks. A single period counter advances on each tick, and every channel compares that counter against its own duty threshold. Each channel's duty is chosen on its own, but no channel can have a period of its own.

There are two period modes. In full-width mode the counter runs through its whole range. In compare-wrap mode, channel 0's threshold becomes the last count of the period. This gives a finer choice of period, and channel 0 then no longer drives its pin. Because the counter has a fixed width and the prescaler has a limited exponent range, there are periods that neither mode can produce.

Settings are written through a plain register write port. They land in pending copies and are moved into the active copies only at a period boundary, so no output ever shows a partial period. There is no streaming data path, so no port uses valid/ready.

Top module: `pwm_shared_period`

## Requirements
- R1: After reset all outputs are low. All pending and active thresholds are 0, the prescale exponent is 0 and the mode is full-width.
- R2: While `en` is low, every output is low and the period counter is held at 0. The active settings copy the pending settings on every clock while `en` is low.
- R3: With `en` high, the period counter advances once every 2^E clocks, where E is the active exponent. E is written at address 4 from `wr_data[3:0]`, and its range is 0 to 15.
- R4: In full-width mode (address 5, `wr_data[0]`=0), the counter goes from 65535 to 0. The period is 65536 counts.
- R5: In compare-wrap mode (address 5, `wr_data[0]`=1), the counter returns to 0 on the count after it equals channel 0's active threshold T0. The period is T0+1 counts.
- R6: Output i is high exactly while the counter is below channel i's active threshold. The threshold for channel i is written at address i (0 to 3) from `wr_data[15:0]`. A threshold of 0 gives a constant low output.
- R7: In compare-wrap mode, output 0 is held low. Any other channel whose threshold is above T0 stays high for the whole period.
- R8: A write while `en` is high takes effect only at the count tick on which the counter wraps. Until that tick, the outputs follow the old settings.
- R9: Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears the counter and the outputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Address: 0-3 thresholds, 4 exponent, 5 mode |
| wr_data | input | 16 | Write data |
| pwm_out | output | 4 | Channel outputs |

## Verification
A write sampled at edge k lands in the pending copy at k. The write then reaches the active copy at the first later edge where `en` is low, or where a count tick meets the wrap count. The counter moves at the edge that ends each prescale interval. Outputs are combinational from the counter, the active thresholds and `en`, so a change is visible in the cycle that follows that edge. The bench drives inputs just after the rising edge. At the same edge as the design, it steps a behavioural model built from these rules, and it compares all four outputs at every falling edge. Directed windows that are whole multiples of the period count high cycles, which confirms the duty fractions independently of phase.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_CHANNELS  = 4;
  localparam int unsigned PWM_COUNT_W   = 16;
  localparam int unsigned PWM_EXP_W     = 4;

  typedef enum logic {
    WRAP_FULL    = 1'b0,
    WRAP_CMP0    = 1'b1
  } wrap_mode_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
#(
  parameter int unsigned NCH    = PWM_CHANNELS,
  parameter int unsigned CW     = PWM_COUNT_W,
  parameter int unsigned EW     = PWM_EXP_W,
  parameter int unsigned AW     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   load,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [CW-1:0]          wr_data,
  output logic [NCH-1:0][CW-1:0] thr_act,
  output logic [EW-1:0]          exp_act,
  output wrap_mode_e             mode_act
);
  localparam logic [AW-1:0] EXP_ADDR  = AW'(NCH);
  localparam logic [AW-1:0] MODE_ADDR = AW'(NCH + 1);

  logic [NCH-1:0][CW-1:0] thr_pend;
  logic [EW-1:0]          exp_pend;
  wrap_mode_e             mode_pend;
  logic                   take;

  assign take = !en || load;

  for (genvar i = 0; i < NCH; i++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        thr_pend[i] <= '0;
        thr_act[i]  <= '0;
      end else begin
        if (take) thr_act[i] <= thr_pend[i];
        if (wr_en && wr_addr == AW'(i)) thr_pend[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_pend  <= '0;
      exp_act   <= '0;
      mode_pend <= WRAP_FULL;
      mode_act  <= WRAP_FULL;
    end else begin
      if (take) begin
        exp_act  <= exp_pend;
        mode_act <= mode_pend;
      end
      if (wr_en && wr_addr == EXP_ADDR)  exp_pend  <= wr_data[EW-1:0];
      if (wr_en && wr_addr == MODE_ADDR) mode_pend <= wrap_mode_e'(wr_data[0]);
    end
  end

  // R8: active settings only move at a wrap tick (or while disabled)
  a_r8_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ($stable(thr_act) && $stable(exp_act) && $stable(mode_act)));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int unsigned EW = PWM_EXP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [EW-1:0] exp_act,
  output logic          tick
);
  localparam int unsigned DW = (1 << EW) - 1;

  logic [DW-1:0] div_q;
  logic [DW-1:0] limit;

  assign limit = ~({DW{1'b1}} << exp_act);
  assign tick  = en && (div_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)            div_q <= '0;
    else if (!en || tick)  div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  // R3: with a nonzero exponent, ticks never land on adjacent clocks
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && exp_act != '0) |=> (!tick || exp_act == '0));
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
  import pwm_pkg::*;
#(
  parameter int unsigned CW = PWM_COUNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  wrap_mode_e    mode_act,
  input  logic [CW-1:0] thr0,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic [CW-1:0] last;
  logic          at_last;

  assign last    = (mode_act == WRAP_CMP0) ? thr0 : {CW{1'b1}};
  assign at_last = (count == last);
  assign wrap    = tick && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) count <= '0;
    else if (tick)     count <= at_last ? '0 : count + 1'b1;
  end

  // R2: disabled holds the counter at zero
  a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));
  // R3: no movement between ticks
  a_r3_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(count));
  // R5: in compare-wrap mode the count never passes channel 0's threshold
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == WRAP_CMP0) |-> (count <= thr0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CW       = PWM_COUNT_W,
  parameter bit          CAN_WRAP = 1'b0
) (
  input  logic          en,
  input  wrap_mode_e    mode_act,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thr,
  output logic          pin
);
  logic borrowed;

  if (CAN_WRAP) begin : g_borrow
    assign borrowed = (mode_act == WRAP_CMP0);
  end else begin : g_plain
    assign borrowed = 1'b0;
  end

  assign pin = en && !borrowed && (count < thr);
endmodule

// File: rtl/pwm_shared_period.sv
module pwm_shared_period
  import pwm_pkg::*;
#(
  parameter int unsigned NCH = PWM_CHANNELS,
  parameter int unsigned CW  = PWM_COUNT_W,
  parameter int unsigned EW  = PWM_EXP_W,
  localparam int unsigned AW = $clog2(NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_out
);
  logic [NCH-1:0][CW-1:0] thr_act;
  logic [EW-1:0]          exp_act;
  wrap_mode_e             mode_act;
  logic                   tick;
  logic                   wrap;
  logic [CW-1:0]          count;

  pwm_cfg_regs #(.NCH(NCH), .CW(CW), .EW(EW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en), .load(wrap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .thr_act(thr_act), .exp_act(exp_act), .mode_act(mode_act)
  );

  pwm_prescaler #(.EW(EW)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .exp_act(exp_act), .tick(tick)
  );

  pwm_period_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .mode_act(mode_act), .thr0(thr_act[0]), .count(count), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.CW(CW), .CAN_WRAP(i == 0)) u_ch (
      .en(en), .mode_act(mode_act), .count(count),
      .thr(thr_act[i]), .pin(pwm_out[i])
    );
  end

  // R2: disabled block drives nothing
  a_r2_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_out == '0));
  // R7: channel 0 pin is silent while it sets the period
  a_r7_ch0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == WRAP_CMP0) |-> !pwm_out[0]);
  // R6: a zero threshold never yields a high pin
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_act[1] == '0) |-> !pwm_out[1]);
endmodule

// File: tb/tb_pwm_shared_period.sv
module tb_pwm_shared_period;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shared_period dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // behavioural reference
  int m_pend[4];
  int m_act[4];
  int m_pexp, m_aexp, m_pmode, m_amode, m_div, m_cnt;

  always @(posedge clk) begin
    bit t, top;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_act[i] = 0; end
      m_pexp = 0; m_aexp = 0; m_pmode = 0; m_amode = 0; m_div = 0; m_cnt = 0;
    end else begin
      t   = en && (m_div == (1 << m_aexp) - 1);
      top = (m_amode != 0) ? (m_cnt == m_act[0]) : (m_cnt == 65535);
      if (!en || (t && top)) begin
        for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
        m_aexp = m_pexp; m_amode = m_pmode;
      end
      if (wr_en) begin
        if (wr_addr < 4) m_pend[wr_addr] = wr_data;
        else if (wr_addr == 4) m_pexp = wr_data & 16'hF;
        else if (wr_addr == 5) m_pmode = wr_data & 16'h1;
      end
      if (!en) begin m_div = 0; m_cnt = 0; end
      else begin
        m_div = t ? 0 : m_div + 1;
        if (t) m_cnt = top ? 0 : m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        bit e;
        e = en && (m_cnt < m_act[i]) && !(i == 0 && m_amode != 0);
        total++;
        if (pwm_out[i] !== e) begin
          bad++;
          $display("FAIL %s cycle %0d ch%0d actual=%b expected=%b", cur_req, cyc, i, pwm_out[i], e);
        end
      end
    end
    if (cyc > WATCHDOG) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic count_high(int ch, int n, int expv, string req);
    int hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hits++;
    end
    #1;
    total++;
    if (hits != expv) begin
      bad++;
      $display("FAIL %s ch%0d high-count actual=%0d expected=%0d", req, ch, hits, expv);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    step(4);
    @(negedge clk);
    total++;
    if (pwm_out !== 4'b0) begin
      bad++; $display("FAIL R1 reset outputs actual=%b expected=0000", pwm_out);
    end
    rst_n = 1'b1;
    step(1);

    // R3 R6 R7: compare-wrap, exponent 2, period 4 counts = 16 clocks
    cur_req = "R3";
    wr(0, 3); wr(1, 2); wr(2, 9); wr(3, 0); wr(4, 2); wr(5, 1);
    step(2);
    en = 1'b1;
    count_high(1, 160, 80, "R3");
    count_high(3, 160, 0, "R6");
    count_high(2, 160, 160, "R7");
    count_high(0, 160, 0, "R7");

    // R8: change channel 1 while running; old value holds until wrap
    cur_req = "R8";
    step(5);
    wr(1, 1);
    step(40);
    count_high(1, 160, 40, "R8");

    // R9: writes to unused addresses change nothing
    cur_req = "R9";
    wr(6, 16'hFFFF); wr(7, 16'h0000);
    step(20);
    count_high(1, 160, 40, "R9");

    // R2: disable clears outputs
    cur_req = "R2";
    en = 1'b0;
    step(1);
    count_high(2, 20, 0, "R2");

    // R5: exponent 0, threshold 5 -> 6-clock period, channel 1 high 3 of 6
    cur_req = "R5";
    wr(4, 0); wr(0, 5); wr(1, 3); wr(2, 6);
    step(1);
    en = 1'b1;
    count_high(1, 60, 30, "R5");
    count_high(2, 60, 60, "R7");

    // R4: full-width mode, exponent 0, 65536-clock period
    cur_req = "R4";
    en = 1'b0;
    wr(5, 0); wr(0, 1); wr(1, 16'h8000); wr(2, 16'hFFFF);
    step(1);
    en = 1'b1;
    count_high(1, 65536, 32768, "R4");
    count_high(2, 65536, 65535, "R4");

    en = 1'b0;
    step(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule